// File: doc/BRIEF.md
# Sensorless Motor Start-up Sequencer

This block takes a three-phase brushless motor drive with no position sensors from standstill to closed-loop running. It works in three modes. First it holds the commutation logic in a dedicated parking state so the rotor settles at a known angle. Next it steps commutation open-loop at a steadily rising rate for a fixed time. Finally it hands commutation timing to an external back-EMF locked loop. Digital counters set the lengths of the parking and open-loop phases.

During the open-loop phase, a phase accumulator produces the stepping rate. Its increment grows by a programmed acceleration step on every clock and stops growing at a programmed ceiling. Each time the accumulator wraps, the block emits a single-cycle commutation-advance strobe. Back-EMF sensing stays off until the open-loop phase ends. An undervoltage fault throws the sequence back to parking at any time and clears all timing state. The sequence starts again once the fault is gone.

Top module: `motor_start_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the mode output is 0 (align), the hold output is 1, and both the sensing enable and the strobe are 0.
- R2: Whenever the mode is 0 (align), the hold output is 1, the sensing enable is 0 and no strobe is issued.
- R3: Align mode lasts max(align_cycles,1) cycles, counted from its first fault-free cycle. It then moves to mode 1 (ramp) and can never go directly to run.
- R4: In ramp cycle k (k = 0 is the first), the rate is r_k = min(r_(k-1) + accel_step, rate_max) with r_(-1) = 0. The accumulator is a_k = (a_(k-1) + r_k) mod 2^ACC_W with a_(-1) = 0. The strobe is high in cycle k exactly when this addition carries out of ACC_W bits.
- R5: The ramp rate never exceeds rate_max. Over a full fault-free ramp of B cycles, the number of strobes is floor(sum of r_k / 2^ACC_W).
- R6: Ramp mode lasts max(ramp_cycles,1) cycles. Throughout it, the hold output and the sensing enable are both 0.
- R7: After the ramp, the mode is 2 (run). In run, the sensing enable is 1, the hold output is 0 and the strobe is 0. Run persists until a fault occurs.
- R8: In any cycle with uv_fault high, the strobe is 0. In the next cycle the mode is align, with the phase timer and the accumulator cleared. While the fault stays high, the block stays in align.
- R9: Mode code 3 never appears on the mode output. If the mode register holds 3, the next mode is align.
- R10: The strobe never stays high for two consecutive cycles (ACC_W exceeds RATE_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uv_fault | input | 1 | Supply undervoltage flag; restarts the sequence |
| align_cycles | input | TIME_W | Length of align mode in clocks |
| ramp_cycles | input | TIME_W | Length of ramp mode in clocks |
| accel_step | input | RATE_W | Amount added to the ramp rate on each ramp clock |
| rate_max | input | RATE_W | Ceiling on the ramp rate |
| mode_o | output | 2 | 0 align, 1 ramp, 2 run |
| adv_strobe | output | 1 | One-cycle commutation-advance pulse during ramp |
| bemf_en | output | 1 | Back-EMF sampler enable |
| align_hold | output | 1 | Forces the commutation logic into its parking state |

## Verification
Two events can land on the same clock: an accumulator wrap that would issue a strobe, and an undervoltage fault that must suppress it and restart the sequence. The bench's reference model predicts the next wrap. The bench raises uv_fault for exactly that cycle and then requires the strobe to stay low and the mode to return to align on the next clock. The end of the ramp timer can also coincide with a wrap; the model compares those cycles the same way, and a strobe issued in the final ramp cycle is legal.

// File: rtl/motor_seq_pkg.sv
package motor_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ALIGN = 2'd0,
    MODE_RAMP  = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_BAD   = 2'd3
  } seq_mode_e;

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         count_en,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q;

  // Phase ends on the cycle whose 1-based index reaches the limit; a limit of 0 acts as 1.
  function automatic logic reached(input logic [W-1:0] cnt, input logic [W-1:0] lim);
    logic [W:0] nxt;
    nxt = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    return nxt >= {1'b0, lim};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (count_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = reached(cnt_q, limit);

endmodule

// File: rtl/ramp_nco.sv
module ramp_nco #(
  parameter int ACC_W  = 16,
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_en,
  input  logic [RATE_W-1:0] accel,
  input  logic [RATE_W-1:0] rate_max,
  output logic              wrap,
  output logic [RATE_W-1:0] rate_q
);

  localparam int PAD_W = ACC_W - RATE_W + 1;

  logic [ACC_W-1:0]  acc_q;
  logic [RATE_W-1:0] rate_nxt;
  logic [ACC_W-1:0]  acc_nxt;

  function automatic logic [RATE_W-1:0] next_rate(input logic [RATE_W-1:0] cur,
                                                   input logic [RATE_W-1:0] stp,
                                                   input logic [RATE_W-1:0] lim);
    logic [RATE_W:0] sum;
    sum = {1'b0, cur} + {1'b0, stp};
    return (sum > {1'b0, lim}) ? lim : sum[RATE_W-1:0];
  endfunction

  function automatic logic [ACC_W:0] accumulate(input logic [ACC_W-1:0] acc,
                                                input logic [RATE_W-1:0] inc);
    return {1'b0, acc} + {{PAD_W{1'b0}}, inc};
  endfunction

  always_comb begin
    rate_nxt          = next_rate(rate_q, accel, rate_max);
    {wrap, acc_nxt}   = accumulate(acc_q, rate_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rate_q <= '0;
    end else if (clear) begin
      acc_q  <= '0;
      rate_q <= '0;
    end else if (step_en) begin
      acc_q  <= acc_nxt;
      rate_q <= rate_nxt;
    end
  end

endmodule

// File: rtl/seq_mode_ctrl.sv
module seq_mode_ctrl
  import motor_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      uv_fault,
  input  logic      phase_done,
  output seq_mode_e mode_q,
  output logic      timer_clear,
  output logic      timer_en,
  output logic      nco_clear,
  output logic      nco_en,
  output logic      strobe_gate,
  output logic      hold,
  output logic      sense_en
);

  seq_mode_e mode_nxt;

  always_comb begin
    mode_nxt = mode_q;
    if (uv_fault) begin
      mode_nxt = MODE_ALIGN;
    end else begin
      unique case (mode_q)
        MODE_ALIGN: if (phase_done) mode_nxt = MODE_RAMP;
        MODE_RAMP:  if (phase_done) mode_nxt = MODE_RUN;
        MODE_RUN:   mode_nxt = MODE_RUN;
        default:    mode_nxt = MODE_ALIGN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_ALIGN;
    else        mode_q <= mode_nxt;
  end

  assign timer_en    = (mode_q == MODE_ALIGN) || (mode_q == MODE_RAMP);
  assign timer_clear = uv_fault || (mode_nxt != mode_q);
  assign nco_en      = (mode_q == MODE_RAMP);
  assign nco_clear   = uv_fault || (mode_q != MODE_RAMP);
  assign strobe_gate = (mode_q == MODE_RAMP) && !uv_fault;
  assign hold        = (mode_q == MODE_ALIGN);
  assign sense_en    = (mode_q == MODE_RUN);

endmodule

// File: rtl/motor_start_seq.sv
module motor_start_seq
  import motor_seq_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int ACC_W  = 16,
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uv_fault,
  input  logic [TIME_W-1:0] align_cycles,
  input  logic [TIME_W-1:0] ramp_cycles,
  input  logic [RATE_W-1:0] accel_step,
  input  logic [RATE_W-1:0] rate_max,
  output logic [1:0]        mode_o,
  output logic              adv_strobe,
  output logic              bemf_en,
  output logic              align_hold
);

  seq_mode_e         mode_q;
  logic              phase_done;
  logic              timer_clear;
  logic              timer_en;
  logic              nco_clear;
  logic              nco_en;
  logic              nco_wrap;
  logic              strobe_gate;
  logic [RATE_W-1:0] nco_rate;
  logic [TIME_W-1:0] phase_limit;

  assign phase_limit = (mode_q == MODE_RAMP) ? ramp_cycles : align_cycles;

  seq_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .uv_fault   (uv_fault),
    .phase_done (phase_done),
    .mode_q     (mode_q),
    .timer_clear(timer_clear),
    .timer_en   (timer_en),
    .nco_clear  (nco_clear),
    .nco_en     (nco_en),
    .strobe_gate(strobe_gate),
    .hold       (align_hold),
    .sense_en   (bemf_en)
  );

  seq_phase_timer #(.W(TIME_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (timer_clear),
    .count_en(timer_en),
    .limit   (phase_limit),
    .done    (phase_done)
  );

  ramp_nco #(.ACC_W(ACC_W), .RATE_W(RATE_W)) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (nco_clear),
    .step_en (nco_en),
    .accel   (accel_step),
    .rate_max(rate_max),
    .wrap    (nco_wrap),
    .rate_q  (nco_rate)
  );

  assign adv_strobe = nco_wrap && strobe_gate;
  assign mode_o     = mode_q;

endmodule

// File: rtl/motor_start_seq_chk.sv
module motor_start_seq_chk #(
  parameter int RATE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uv_fault,
  input logic [1:0]        mode,
  input logic              strobe,
  input logic              sense_en,
  input logic              hold,
  input logic [RATE_W-1:0] rate,
  input logic [RATE_W-1:0] rate_lim
);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'd3); // R9
  AST_FAULT_TO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) uv_fault |=> mode == 2'd0); // R8
  AST_FAULT_MUTES_STROBE: assert property (@(posedge clk) disable iff (!rst_n) uv_fault |-> !strobe); // R8
  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0) |-> (hold && !sense_en && !strobe)); // R2
  AST_ALIGN_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd0) |=> mode != 2'd2); // R3
  AST_RAMP_BLIND: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd1) |-> (!hold && !sense_en)); // R6
  AST_RUN_SENSE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'd2) |-> (sense_en && !hold && !strobe)); // R7
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ((mode == 2'd2) && !uv_fault) |=> mode == 2'd2); // R7
  AST_RATE_CAP: assert property (@(posedge clk) disable iff (!rst_n) rate <= rate_lim); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) strobe |=> !strobe); // R10

endmodule

bind motor_start_seq motor_start_seq_chk #(.RATE_W(RATE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .uv_fault(uv_fault),
  .mode    (mode_o),
  .strobe  (adv_strobe),
  .sense_en(bemf_en),
  .hold    (align_hold),
  .rate    (nco_rate),
  .rate_lim(rate_max)
);

// File: tb/motor_start_seq_tb.sv
module motor_start_seq_tb;

  localparam int TW = 16;
  localparam int AW = 16;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          uv;
  logic [TW-1:0] a_cyc;
  logic [TW-1:0] b_cyc;
  logic [RW-1:0] accel;
  logic [RW-1:0] rmax;
  logic [1:0]    mode_o;
  logic          adv_strobe;
  logic          bemf_en;
  logic          align_hold;

  always #5 clk = ~clk;

  motor_start_seq #(.TIME_W(TW), .ACC_W(AW), .RATE_W(RW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_fault    (uv),
    .align_cycles(a_cyc),
    .ramp_cycles (b_cyc),
    .accel_step  (accel),
    .rate_max    (rmax),
    .mode_o      (mode_o),
    .adv_strobe  (adv_strobe),
    .bemf_en     (bemf_en),
    .align_hold  (align_hold)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_mode, m_cnt, m_rate, m_acc;
  int tally;
  bit prev_strobe;

  function automatic int lim1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int m_next_rate();
    int r;
    r = m_rate + int'(accel);
    if (r > int'(rmax)) r = int'(rmax);
    return r;
  endfunction

  function automatic bit m_wrap();
    return (m_mode == 1) && !uv && ((m_acc + m_next_rate()) >= (1 << AW));
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string tag;
    bit es;
    es = m_wrap();
    if (uv)               tag = "R8";
    else if (m_mode == 0) tag = "R2/R3";
    else if (m_mode == 1) tag = "R4/R6";
    else                  tag = "R7";
    check(int'(mode_o) == m_mode, tag, "mode", int'(mode_o), m_mode);
    check(align_hold == (m_mode == 0), tag, "hold", int'(align_hold), int'(m_mode == 0));
    check(bemf_en == (m_mode == 2), tag, "bemf_en", int'(bemf_en), int'(m_mode == 2));
    check(adv_strobe == es, tag, "strobe", int'(adv_strobe), int'(es));
    check(mode_o != 2'd3, "R9", "mode code", int'(mode_o), m_mode);
    check(!(adv_strobe && prev_strobe), "R10", "strobe run", int'(adv_strobe), 0);
  endtask

  task automatic model_step();
    if (uv) begin
      m_mode = 0; m_cnt = 0; m_rate = 0; m_acc = 0;
    end else begin
      case (m_mode)
        0: if (m_cnt + 1 >= lim1(int'(a_cyc))) begin m_mode = 1; m_cnt = 0; end
           else m_cnt++;
        1: begin
          m_rate = m_next_rate();
          m_acc  = (m_acc + m_rate) % (1 << AW);
          if (m_cnt + 1 >= lim1(int'(b_cyc))) begin
            m_mode = 2; m_cnt = 0; m_rate = 0; m_acc = 0;
          end else m_cnt++;
        end
        default: m_mode = 2;
      endcase
    end
  endtask

  task automatic tick();
    #1;
    compare();
    if (adv_strobe && mode_o == 2'd1) tally++;
    prev_strobe = adv_strobe;
    model_step();
    @(posedge clk);
    #1;
  endtask

  // independent closed form for the strobe count over a whole ramp
  function automatic int ramp_strobes(input int b, input int stp, input int mx);
    longint tot;
    longint r;
    tot = 0;
    for (int k = 0; k < lim1(b); k++) begin
      r = longint'(k + 1) * stp;
      if (r > mx) r = mx;
      tot += r;
    end
    return int'(tot / (longint'(1) << AW));
  endfunction

  task automatic run_to_run(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (m_mode == 2) break;
      tick();
    end
  endtask

  task automatic restart(input int a, input int b, input int stp, input int mx);
    uv = 1'b1;
    tick();
    a_cyc = TW'(a); b_cyc = TW'(b); accel = RW'(stp); rmax = RW'(mx);
    tick();
    uv = 1'b0;
    tally = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uv = 1'b0;
    a_cyc = 16'd5; b_cyc = 16'd300; accel = 12'd20; rmax = 12'd2000;
    m_mode = 0; m_cnt = 0; m_rate = 0; m_acc = 0; tally = 0; prev_strobe = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(mode_o == 2'd0 && align_hold && !bemf_en && !adv_strobe, "R1", "reset outputs",
          int'({mode_o, align_hold, bemf_en, adv_strobe}), 4);
    rst_n = 1'b1;
    #1;
    check(mode_o == 2'd0 && align_hold && !bemf_en && !adv_strobe, "R1", "after release",
          int'({mode_o, align_hold, bemf_en, adv_strobe}), 4);
    @(posedge clk);
    #1;
    m_cnt = 1;  // the first fault-free align cycle has already been counted

    // R3 R4 R5 R6: rising rate that reaches its ceiling part way through the ramp
    run_to_run(1000);
    check(tally == ramp_strobes(300, 20, 2000), "R5", "ramp strobe count", tally, ramp_strobes(300, 20, 2000));
    repeat (10) tick();

    // R5: step above the ceiling saturates at once
    restart(3, 40, 4095, 3000);
    run_to_run(500);
    check(tally == ramp_strobes(40, 4095, 3000), "R5", "saturated strobe count", tally, ramp_strobes(40, 4095, 3000));
    repeat (5) tick();

    // R8: fault raised in exactly the cycle of a predicted wrap
    restart(2, 200, 50, 3000);
    for (int i = 0; i < 600; i++) begin
      if (m_mode == 1 && m_wrap()) begin
        uv = 1'b1;
        tick();
        uv = 1'b0;
        check(mode_o == 2'd0, "R8", "align after fault", int'(mode_o), 0);
        break;
      end
      tick();
    end
    run_to_run(600);
    repeat (5) tick();

    // R3 R6: zero lengths act as a single cycle each
    restart(0, 0, 100, 4000);
    repeat (8) tick();

    // R8: long fault holds align, then a full sequence
    uv = 1'b1;
    repeat (20) tick();
    uv = 1'b0;
    a_cyc = 16'd7; b_cyc = 16'd120; accel = 12'd300; rmax = 12'd3500;
    tally = 0;
    run_to_run(500);
    check(tally == ramp_strobes(120, 300, 3500), "R5", "strobe count after long fault", tally, ramp_strobes(120, 300, 3500));
    repeat (5) tick();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule